// File: doc/BRIEF.md
# Multibank Pipelined Memory Crossbar

A shared data memory assembled from several independent single-port word banks and reached through a crossbar by several load/store client ports. Every client may present one read or one write per cycle. The word address is interleaved across the banks, so consecutive words fall in consecutive banks and clients working on different banks proceed in parallel.

When more than one client targets the same bank in a cycle, a rotating-priority arbiter in front of that bank accepts exactly one. The others see their grant low and keep their request up until it is accepted. A client that is alone on its bank is never held back by a conflict elsewhere. Read data returns to the issuing client with a valid flag a fixed number of cycles after acceptance: 2 or 3, set by a parameter. The client count and the bank count are independent parameters, up to 8 by 8.

Top module: `mbank_xbar`

## Requirements
- R1: The bank is the word index modulo N_BANK, taken from byte-address bits [2+BANK_W-1:2]; the row inside the bank is the next ROW_W bits above those.
- R2: A granted write changes only the byte lanes k with be_i[k]=1, where lane k is data bits [8k+7:8k]; other lanes of the word keep their value.
- R3: Each bank accepts at most one client per cycle, and clients that target distinct banks are all granted in the same cycle.
- R4: Among clients contending for one bank, the grant goes to the first requester at or after (index of that bank's previous winner + 1) modulo N_CLI; after reset the search starts at client 0.
- R5: A client that is the only requester of its bank is granted in that cycle whatever happens on other banks; a losing client sees gnt_o low and its request writes nothing and returns no data.
- R6: A granted read raises rvalid_o of the issuing client, with the word on rdata_o, exactly PIPE_DEPTH cycles after the grant cycle; writes and ungranted requests raise no rvalid_o.
- R7: While rst_ni is low rvalid_o is low and reads in flight are dropped; gnt_o is low for a client whose req_i is low.
- R8: A read returns the word as left by all writes granted in earlier cycles.
- R9: PIPE_DEPTH may be 2 or 3; it changes only the read latency, not grants or data.
- R10: A client with req_i low changes no memory, even if we_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CLI | Per-client request |
| we_i | input | N_CLI | Per-client write (1) or read (0) |
| addr_i | input | N_CLI x ADDR_W | Per-client byte address |
| wdata_i | input | N_CLI x 32 | Per-client write data |
| be_i | input | N_CLI x 4 | Per-client byte-lane write enables |
| gnt_o | output | N_CLI | Request accepted this cycle |
| rvalid_o | output | N_CLI | Read data valid |
| rdata_o | output | N_CLI x 32 | Read data |

## Verification
Grants are combinational and due in the same cycle as the request, so the bench drives each vector on the falling edge and compares gnt_o 5 ns later, before the next rising edge. Read responses are due PIPE_DEPTH rising edges after the grant cycle; the bench computes each expected word from its own shadow memory at grant time and files it in a slot two cycles ahead for the default instance and three cycles ahead for a second instance built with PIPE_DEPTH=3. Every cycle both instances' rvalid_o and rdata_o are compared against the slot for that cycle, so an early, late or missing response is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/mbx_rr_arb.sv
module mbx_rr_arb #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] win_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             found;
  logic             armed_q;
  int               idx;

  // first requester at or after ptr_q, wrapping
  always_comb begin
    gnt_o = '0;
    win_o = '0;
    found = 1'b0;
    idx   = 0;
    for (int off = 0; off < int'(N_REQ); off++) begin
      idx = (int'(ptr_q) + off) % int'(N_REQ);
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win_o      = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (|req_i) ptr_q <= (win_o == IDX_W'(N_REQ - 1)) ? '0 : win_o + 1'b1;
    end
  end

  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r3_gnt_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R4: a persisting contention never hands the bank to the same client twice
  a_r4_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && req_i == $past(req_i) && $countones(req_i) > 1) |-> gnt_o != $past(gnt_o));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned N_CLI = 4,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned CLI_W = $clog2(N_CLI)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  word_t            wdata_i,
  input  lane_t            be_i,
  input  logic [CLI_W-1:0] cli_i,
  output logic             rvalid_o,
  output logic [CLI_W-1:0] rcli_o,
  output word_t            rdata_o
);
  word_t mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      for (int k = 0; k < int'(LANES); k++) begin
        if (be_i[k]) mem_q[row_i][8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end
    if (en_i && !we_i) rdata_o <= mem_q[row_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rcli_o   <= '0;
    end else begin
      rvalid_o <= en_i && !we_i;
      rcli_o   <= cli_i;
    end
  end

  a_r6_wr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> !rvalid_o);
endmodule

// File: rtl/mbx_resp_pipe.sv
module mbx_resp_pipe
  import mbx_pkg::*;
#(
  parameter int unsigned N_BANK = 4,
  parameter int unsigned N_CLI  = 4,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned CLI_W = $clog2(N_CLI),
  localparam int unsigned NSTG  = DEPTH - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_BANK-1:0]            b_rvalid_i,
  input  logic [N_BANK-1:0][CLI_W-1:0] b_cli_i,
  input  word_t [N_BANK-1:0]           b_rdata_i,
  output logic [N_CLI-1:0]             rvalid_o,
  output word_t [N_CLI-1:0]            rdata_o
);
  logic [N_CLI-1:0][N_BANK-1:0] hit_m;
  logic [N_CLI-1:0]             hit_v;
  word_t [N_CLI-1:0]            hit_d;
  logic [NSTG-1:0][N_CLI-1:0]   v_q;
  word_t [NSTG-1:0][N_CLI-1:0]  d_q;

  always_comb begin
    hit_m = '0;
    hit_v = '0;
    hit_d = '0;
    for (int c = 0; c < int'(N_CLI); c++) begin
      for (int b = 0; b < int'(N_BANK); b++) begin
        if (b_rvalid_i[b] && b_cli_i[b] == CLI_W'(c)) begin
          hit_m[c][b] = 1'b1;
          hit_v[c]    = 1'b1;
          hit_d[c]    = b_rdata_i[b];
        end
      end
    end
  end

  for (genvar s = 0; s < int'(NSTG); s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= '0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= hit_v;
          d_q[s] <= hit_d;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= '0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign rvalid_o = v_q[NSTG-1];
  assign rdata_o  = d_q[NSTG-1];

  for (genvar c = 0; c < int'(N_CLI); c++) begin : g_chk
    // R6: one client receives from at most one bank per cycle
    a_r6_single_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit_m[c]) <= 1);
  end
endmodule

// File: rtl/mbank_xbar.sv
module mbank_xbar
  import mbx_pkg::*;
#(
  parameter int unsigned N_CLI      = 4,
  parameter int unsigned N_BANK     = 4,
  parameter int unsigned ROWS       = 64,
  parameter int unsigned PIPE_DEPTH = 2,
  localparam int unsigned BANK_W = $clog2(N_BANK),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned CLI_W  = $clog2(N_CLI),
  localparam int unsigned ADDR_W = OFS_W + BANK_W + ROW_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CLI-1:0]             req_i,
  input  logic [N_CLI-1:0]             we_i,
  input  logic [N_CLI-1:0][ADDR_W-1:0] addr_i,
  input  logic [N_CLI-1:0][WORD_W-1:0] wdata_i,
  input  logic [N_CLI-1:0][LANES-1:0]  be_i,
  output logic [N_CLI-1:0]             gnt_o,
  output logic [N_CLI-1:0]             rvalid_o,
  output logic [N_CLI-1:0][WORD_W-1:0] rdata_o
);
  logic [N_CLI-1:0][BANK_W-1:0]  sel;
  logic [N_CLI-1:0][ROW_W-1:0]   row;
  logic [N_BANK-1:0][N_CLI-1:0]  breq;
  logic [N_BANK-1:0][N_CLI-1:0]  bgnt;
  logic [N_BANK-1:0][CLI_W-1:0]  bwin;
  logic [N_BANK-1:0]             b_rv;
  logic [N_BANK-1:0][CLI_W-1:0]  b_cli;
  word_t [N_BANK-1:0]            b_rd;
  word_t [N_CLI-1:0]             rd_w;

  for (genvar c = 0; c < int'(N_CLI); c++) begin : g_dec
    assign sel[c] = addr_i[c][OFS_W +: BANK_W];
    assign row[c] = addr_i[c][OFS_W + BANK_W +: ROW_W];
  end

  for (genvar b = 0; b < int'(N_BANK); b++) begin : g_bank
    always_comb begin
      for (int c = 0; c < int'(N_CLI); c++) begin
        breq[b][c] = req_i[c] && (sel[c] == BANK_W'(b));
      end
    end

    mbx_rr_arb #(.N_REQ(N_CLI)) i_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (breq[b]),
      .gnt_o  (bgnt[b]),
      .win_o  (bwin[b])
    );

    mbx_bank #(.ROWS(ROWS), .N_CLI(N_CLI)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (|breq[b]),
      .we_i     (we_i[bwin[b]]),
      .row_i    (row[bwin[b]]),
      .wdata_i  (wdata_i[bwin[b]]),
      .be_i     (be_i[bwin[b]]),
      .cli_i    (bwin[b]),
      .rvalid_o (b_rv[b]),
      .rcli_o   (b_cli[b]),
      .rdata_o  (b_rd[b])
    );
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < int'(N_BANK); b++) gnt_o = gnt_o | bgnt[b];
  end

  mbx_resp_pipe #(.N_BANK(N_BANK), .N_CLI(N_CLI), .DEPTH(PIPE_DEPTH)) i_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .b_rvalid_i (b_rv),
    .b_cli_i    (b_cli),
    .b_rdata_i  (b_rd),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rd_w)
  );
  assign rdata_o = rd_w;

  // cycles since reset, saturating at PIPE_DEPTH, gates the latency check
  logic [1:0] live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       live_q <= '0;
    else if (live_q != 2'(PIPE_DEPTH)) live_q <= live_q + 1'b1;
  end

  for (genvar c = 0; c < int'(N_CLI); c++) begin : g_chk
    a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q == 2'(PIPE_DEPTH)) |-> (rvalid_o[c] == $past(gnt_o[c] && !we_i[c], PIPE_DEPTH)));
    a_r5_free_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[c] && $countones(breq[sel[c]]) == 1) |-> gnt_o[c]);
    a_r7_no_req_no_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i[c] |-> !gnt_o[c]);
  end
endmodule

// File: tb/test_mbank_xbar.sv
module test_mbank_xbar;
  localparam int NC = 4;
  localparam int AW = 10;

  typedef struct packed {
    logic [3:0]      req;
    logic [3:0]      we;
    logic [3:0]      be;
    logic [3:0][7:0] widx;  // word index per client, [3] is client 3
    logic [3:0]      gnt;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{4'b1111, 4'b1111, 4'b1111, {8'd3, 8'd2, 8'd1, 8'd0},  4'b1111},
    '{4'b1111, 4'b1111, 4'b1111, {8'd7, 8'd6, 8'd5, 8'd4},  4'b1111},
    '{4'b1111, 4'b0000, 4'b1111, {8'd3, 8'd2, 8'd1, 8'd0},  4'b1111},
    '{4'b1111, 4'b0000, 4'b1111, {8'd4, 8'd0, 8'd4, 8'd0},  4'b0010},
    '{4'b1111, 4'b0000, 4'b1111, {8'd4, 8'd0, 8'd4, 8'd0},  4'b0100},
    '{4'b1111, 4'b0000, 4'b1111, {8'd4, 8'd0, 8'd4, 8'd0},  4'b1000},
    '{4'b1111, 4'b0000, 4'b1111, {8'd4, 8'd0, 8'd4, 8'd0},  4'b0001},
    '{4'b0111, 4'b0000, 4'b1111, {8'd0, 8'd5, 8'd0, 8'd4},  4'b0110},
    '{4'b0100, 4'b0100, 4'b0101, {8'd0, 8'd0, 8'd0, 8'd0},  4'b0100},
    '{4'b0100, 4'b0000, 4'b1111, {8'd0, 8'd0, 8'd0, 8'd0},  4'b0100},
    '{4'b0000, 4'b1111, 4'b1111, {8'd3, 8'd2, 8'd1, 8'd1},  4'b0000},
    '{4'b0001, 4'b0000, 4'b1111, {8'd0, 8'd0, 8'd0, 8'd1},  4'b0001},
    '{4'b0011, 4'b0011, 4'b1111, {8'd0, 8'd0, 8'd13, 8'd9}, 4'b0010},
    '{4'b0000, 4'b0000, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},  4'b0000},
    '{4'b0000, 4'b0000, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},  4'b0000},
    '{4'b0000, 4'b0000, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd0},  4'b0000}
  };

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NC-1:0]         req_i = '0;
  logic [NC-1:0]         we_i = '0;
  logic [NC-1:0][AW-1:0] addr_i = '0;
  logic [NC-1:0][31:0]   wdata_i = '0;
  logic [NC-1:0][3:0]    be_i = '0;
  logic [NC-1:0]         gnt2, gnt3, rv2, rv3;
  logic [NC-1:0][31:0]   rd2, rd3;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  logic [31:0]   shadow [256];
  logic [NC-1:0] ev2 [8];
  logic [NC-1:0] ev3 [8];
  logic [31:0]   ed2 [8][NC];
  logic [31:0]   ed3 [8][NC];

  always #10 clk = ~clk;

  mbank_xbar i_mbank_xbar (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .gnt_o(gnt2), .rvalid_o(rv2), .rdata_o(rd2)
  );

  mbank_xbar #(.PIPE_DEPTH(3)) i_mbank_xbar_d3 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .gnt_o(gnt3), .rvalid_o(rv3), .rdata_o(rd3)
  );

  function automatic logic [31:0] wd(int i, int c);
    return {8'(i), 8'(c), 8'hC3, 8'(i * 7 + c)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      ev2[s] = '0;
      ev3[s] = '0;
    end
    for (int w = 0; w < 256; w++) shadow[w] = '0;

    // R7: reset state
    repeat (3) @(negedge clk);
    #5;
    chk("R7 rvalid in reset d2", 32'(rv2), 32'h0);
    chk("R7 rvalid in reset d3", 32'(rv3), 32'h0);
    chk("R7 gnt without req", 32'(gnt2), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      req_i = VEC[i].req;
      we_i  = VEC[i].we;
      for (int c = 0; c < NC; c++) begin
        addr_i[c]  = {VEC[i].widx[c], 2'b00};
        wdata_i[c] = wd(i, c);
        be_i[c]    = VEC[i].be;
      end
      #5;
      // R1 interleave (rows 0-2), R4 rotation (3-6), R5 losers/free banks (7, 12), R10 (10)
      chk("R1 R3 R4 R5 R10 gnt", 32'(gnt2), 32'(VEC[i].gnt));
      chk("R9 gnt matches depth-3", 32'(gnt3), 32'(VEC[i].gnt));
      for (int c = 0; c < NC; c++) begin
        chk("R6 rvalid depth-2", 32'(rv2[c]), 32'(ev2[i % 8][c]));
        if (ev2[i % 8][c]) chk("R2 R8 rdata depth-2", rd2[c], ed2[i % 8][c]);
        chk("R9 rvalid depth-3", 32'(rv3[c]), 32'(ev3[i % 8][c]));
        if (ev3[i % 8][c]) chk("R9 rdata depth-3", rd3[c], ed3[i % 8][c]);
      end
      ev2[i % 8] = '0;
      ev3[i % 8] = '0;
      for (int c = 0; c < NC; c++) begin
        if (VEC[i].gnt[c] && !VEC[i].we[c]) begin
          ev2[(i + 2) % 8][c] = 1'b1;
          ed2[(i + 2) % 8][c] = shadow[VEC[i].widx[c]];
          ev3[(i + 3) % 8][c] = 1'b1;
          ed3[(i + 3) % 8][c] = shadow[VEC[i].widx[c]];
        end
      end
      for (int c = 0; c < NC; c++) begin
        if (VEC[i].gnt[c] && VEC[i].we[c]) begin
          for (int k = 0; k < 4; k++)
            if (VEC[i].be[k]) shadow[VEC[i].widx[c]][8*k +: 8] = wd(i, c) >> (8 * k);
        end
      end
    end

    // R7: reset drops a read in flight
    @(negedge clk);
    req_i = 4'b0001;
    we_i = '0;
    addr_i[0] = '0;
    @(negedge clk);
    req_i = '0;
    rst_ni = 1'b0;
    #5;
    chk("R7 rvalid dropped d2", 32'(rv2), 32'h0);
    chk("R7 rvalid dropped d3", 32'(rv3), 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #5;
      chk("R7 no stale rvalid d2", 32'(rv2), 32'h0);
      chk("R7 no stale rvalid d3", 32'(rv3), 32'h0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule